// File: doc/BRIEF.md
# APB General-Purpose I/O Controller with Line Interrupts

This block is a general-purpose I/O controller that sits on an APB bus. It holds up to four banks of up to 32 lines. Each bank has an output value register, a direction register that drives a per-line output-enable, and a read-only view of the synchronized pin state. The pads themselves are outside the block. It drives `gpio_out` and `gpio_oe` and samples `gpio_in`.

Bank 0 also carries an interrupt unit. Each of its lines can be set to level or edge sensitivity, high/rising or low/falling polarity, enabled, masked and debounced. Edge events are held in a latch until software writes a one to the matching end-of-interrupt bit. The block reports the per-line masked status on `irq_vec` and the OR of all lines on `irq_out`. Software that needs both edges flips the polarity after each event, because the hardware has no both-edges mode. The parameter `ALT_MAP` selects a second register layout for the interrupt registers.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: Bank n has its output value register at offset 0x0C*n and its direction register at 0x0C*n+4. A write takes effect on `gpio_out`/`gpio_oe` bits [32n+31:32n] at the clock edge of the APB access phase, and the register reads back what was written.
- R2: Reading offset 0x50+4*n returns bank n's pins after a two-flop synchronizer.
- R3: Every access completes with no wait state (`apb_pready`=1, `apb_pslverr`=0). Read data is captured at the setup phase and held until the next setup. Unmapped offsets, and banks at or above NUM_PORTS, read as zero. Writes to read-only offsets (pin input, status, raw status) change nothing.
- R4: With ALT_MAP=0 the bank-0 interrupt registers sit at the following offsets: masked status 0x40, polarity 0x3C, EOI 0x4C (write-only, reads zero), line enable 0x30, raw status 0x60, type 0x38, debounce enable 0x48, mask 0x34. Configuration registers read back what was written.
- R5: A line with type bit 1 is edge sensitive. Polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. The latch stays set after the pin returns.
- R6: A line with type bit 0 is level sensitive. It is active while the pin equals its polarity bit (1 = active high, 0 = active low). It follows the pin, and EOI writes have no effect on it.
- R7: Writing 1 to an EOI bit clears that line's edge latch. Bits written as 0 keep their latches.
- R8: Mask bit 1 removes the line from `irq_vec`, `irq_out` and masked status (0x40), while raw status (0x60) still shows it.
- R9: Enable bit 0 removes the line from raw status, masked status and `irq_vec`. Clearing the enable also clears the line's edge latch, and edges on a disabled line are not latched.
- R10: `irq_out` is 1 exactly when some bit of `irq_vec` is 1.
- R11: With a line's debounce bit set, a new pin level is accepted only after it has been seen at two consecutive debounce ticks (one tick every DB_DIV clocks). A pulse shorter than one tick period is ignored. With the bit clear, the same pulse is seen.
- R12: With ALT_MAP=1 the layout changes: mask moves to 0x44, type to 0x34, polarity to 0x38, masked status to 0x3C and EOI to 0x40. Enable, debounce and all bank registers stay put.
- R13: After a synchronous reset every register is zero, `gpio_out`, `gpio_oe`, `irq_vec` and `irq_out` are zero, and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| apb_psel | input | 1 | APB select |
| apb_penable | input | 1 | APB access phase |
| apb_pwrite | input | 1 | APB write when 1 |
| apb_paddr | input | 8 | APB byte offset |
| apb_pwdata | input | 32 | APB write data |
| apb_prdata | output | 32 | APB read data |
| apb_pready | output | 1 | Always 1 |
| apb_pslverr | output | 1 | Always 0 |
| gpio_in | input | NUM_PORTS*PORT_W | Pin inputs, bank n at [PORT_W*n +: PORT_W] |
| gpio_out | output | NUM_PORTS*PORT_W | Output values |
| gpio_oe | output | NUM_PORTS*PORT_W | Output enables (1 = drive) |
| irq_vec | output | PORT_W | Registered per-line masked status of bank 0 |
| irq_out | output | 1 | Registered OR of all masked status bits |

## Verification
On every cycle the assertions check four things. `irq_out` always agrees with `irq_vec`. A masked or disabled line never reaches `irq_vec`. An edge latch never survives a cycle in which its enable was clear. Read data holds still between setup phases. The directed scenarios cover what needs a stimulus history: the rising and falling edge choice, the level polarity, EOI clearing only its own bits and not touching level lines, a glitch rejected with debounce on but caught with it off, and the alternate register layout on a second instance.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int APB_DW      = 32;
  localparam int APB_AW      = 8;
  localparam int MAX_BANKS   = 4;
  localparam int BANK_STRIDE = 12;
  localparam int PIN_STRIDE  = 4;
  localparam int PIN_BASE    = 'h50;

  typedef enum logic [3:0] {
    RK_NONE, RK_DATA, RK_DIR, RK_PIN, RK_EN, RK_MASK, RK_TYPE,
    RK_POL, RK_STAT, RK_RAW, RK_DEB, RK_EOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Map a byte offset to a register kind and bank, for either layout.
  function automatic reg_sel_t decode_addr(input logic [APB_AW-1:0] a,
                                           input logic alt,
                                           input int nbanks);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.bank = '0;
    for (int b = 0; b < MAX_BANKS; b++) begin
      if (b < nbanks) begin
        if (a == APB_AW'(b * BANK_STRIDE)) begin
          r.kind = RK_DATA; r.bank = 2'(b);
        end
        if (a == APB_AW'(b * BANK_STRIDE + 4)) begin
          r.kind = RK_DIR; r.bank = 2'(b);
        end
        if (a == APB_AW'(PIN_BASE + b * PIN_STRIDE)) begin
          r.kind = RK_PIN; r.bank = 2'(b);
        end
      end
    end
    if (a == 8'h30) r.kind = RK_EN;
    if (a == 8'h48) r.kind = RK_DEB;
    if (a == 8'h60) r.kind = RK_RAW;
    if (!alt) begin
      if (a == 8'h34) r.kind = RK_MASK;
      if (a == 8'h38) r.kind = RK_TYPE;
      if (a == 8'h3c) r.kind = RK_POL;
      if (a == 8'h40) r.kind = RK_STAT;
      if (a == 8'h4c) r.kind = RK_EOI;
    end else begin
      if (a == 8'h44) r.kind = RK_MASK;
      if (a == 8'h34) r.kind = RK_TYPE;
      if (a == 8'h38) r.kind = RK_POL;
      if (a == 8'h3c) r.kind = RK_STAT;
      if (a == 8'h40) r.kind = RK_EOI;
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] deb_en_i,
  output logic [W-1:0] filt_o
);
  logic [W-1:0] smp_q, filt_q, accept;

  // A debounced line takes a new level only when two successive
  // tick samples agree; other lines follow the synchronizer.
  assign accept = ~deb_en_i | ({W{tick_i}} & ~(smp_q ^ sync_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      filt_q <= '0;
    end else begin
      if (tick_i) smp_q <= sync_i;
      filt_q <= (sync_i & accept) | (filt_q & ~accept);
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic         wr_en_i,
  input  logic         wr_mask_i,
  input  logic         wr_type_i,
  input  logic         wr_pol_i,
  input  logic         wr_eoi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] type_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] vec_o,
  output logic         any_o
);
  logic [W-1:0] en_q, mask_q, type_q, pol_q, prev_q, latch_q, vec_q;
  logic         any_q;
  logic [W-1:0] rise, fall, hit, lvl_act, clr, raw, stat;

  assign rise    = lvl_i & ~prev_q;
  assign fall    = ~lvl_i & prev_q;
  assign hit     = type_q & ((pol_q & rise) | (~pol_q & fall));
  assign lvl_act = ~type_q & ~(lvl_i ^ pol_q);
  assign clr     = wr_eoi_i ? wdata_i : '0;
  assign raw     = en_q & ((type_q & latch_q) | lvl_act);
  assign stat    = raw & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      mask_q  <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      vec_q   <= '0;
      any_q   <= 1'b0;
    end else begin
      if (wr_en_i)   en_q   <= wdata_i;
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_type_i) type_q <= wdata_i;
      if (wr_pol_i)  pol_q  <= wdata_i;
      prev_q  <= lvl_i;
      // a new event wins over a same-cycle clear; disabled lines drop
      latch_q <= en_q & ((latch_q & ~clr) | hit);
      vec_q   <= stat;
      any_q   <= |stat;
    end
  end

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign type_o  = type_q;
  assign pol_o   = pol_q;
  assign latch_o = latch_q;
  assign raw_o   = raw;
  assign stat_o  = stat;
  assign vec_o   = vec_q;
  assign any_o   = any_q;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int DB_DIV    = 8,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          apb_psel,
  input  logic                          apb_penable,
  input  logic                          apb_pwrite,
  input  logic [APB_AW-1:0]             apb_paddr,
  input  logic [APB_DW-1:0]             apb_pwdata,
  output logic [APB_DW-1:0]             apb_prdata,
  output logic                          apb_pready,
  output logic                          apb_pslverr,
  input  logic [NUM_PORTS*PORT_W-1:0]   gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_oe,
  output logic [PORT_W-1:0]             irq_vec,
  output logic                          irq_out
);
  localparam int LINES = NUM_PORTS * PORT_W;

  reg_sel_t            sel;
  logic                setup_rd, acc_wr;
  logic [PORT_W-1:0]   wbits;
  logic                tick;
  logic [LINES-1:0]    pins_sync;
  logic [PORT_W-1:0]   bank0_filt;
  logic [PORT_W-1:0]   deb_q;
  logic [PORT_W-1:0]   dout_q [NUM_PORTS];
  logic [PORT_W-1:0]   dir_q  [NUM_PORTS];
  logic [PORT_W-1:0]   irq_en, irq_mask, irq_type, irq_pol, irq_latch, irq_raw, irq_stat;
  logic [APB_DW-1:0]   rd_val, prdata_q;

  assign sel      = decode_addr(apb_paddr, ALT_MAP, NUM_PORTS);
  assign setup_rd = apb_psel & ~apb_penable & ~apb_pwrite;
  assign acc_wr   = apb_psel & apb_penable & apb_pwrite;
  assign wbits    = apb_pwdata[PORT_W-1:0];

  gpio_tick_gen #(.DIV(DB_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  gpio_sync #(.W(LINES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (gpio_in),
    .sync_o (pins_sync)
  );

  gpio_debounce #(.W(PORT_W)) u_deb (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .sync_i   (pins_sync[PORT_W-1:0]),
    .deb_en_i (deb_q),
    .filt_o   (bank0_filt)
  );

  // Bank registers, one set per bank.
  for (genvar b = 0; b < NUM_PORTS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        dout_q[b] <= '0;
        dir_q[b]  <= '0;
      end else if (acc_wr && sel.bank == 2'(b)) begin
        if (sel.kind == RK_DATA) dout_q[b] <= wbits;
        if (sel.kind == RK_DIR)  dir_q[b]  <= wbits;
      end
    end
    assign gpio_out[b*PORT_W +: PORT_W] = dout_q[b];
    assign gpio_oe[b*PORT_W +: PORT_W]  = dir_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) deb_q <= '0;
    else if (acc_wr && sel.kind == RK_DEB) deb_q <= wbits;
  end

  gpio_irq_unit #(.W(PORT_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (bank0_filt),
    .wr_en_i   (acc_wr && sel.kind == RK_EN),
    .wr_mask_i (acc_wr && sel.kind == RK_MASK),
    .wr_type_i (acc_wr && sel.kind == RK_TYPE),
    .wr_pol_i  (acc_wr && sel.kind == RK_POL),
    .wr_eoi_i  (acc_wr && sel.kind == RK_EOI),
    .wdata_i   (wbits),
    .en_o      (irq_en),
    .mask_o    (irq_mask),
    .type_o    (irq_type),
    .pol_o     (irq_pol),
    .latch_o   (irq_latch),
    .raw_o     (irq_raw),
    .stat_o    (irq_stat),
    .vec_o     (irq_vec),
    .any_o     (irq_out)
  );

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RK_DATA, RK_DIR, RK_PIN: begin
        for (int b = 0; b < NUM_PORTS; b++) begin
          if (sel.bank == 2'(b)) begin
            if (sel.kind == RK_DATA) rd_val = APB_DW'(dout_q[b]);
            if (sel.kind == RK_DIR)  rd_val = APB_DW'(dir_q[b]);
            if (sel.kind == RK_PIN)  rd_val = APB_DW'(pins_sync[b*PORT_W +: PORT_W]);
          end
        end
      end
      RK_EN:   rd_val = APB_DW'(irq_en);
      RK_MASK: rd_val = APB_DW'(irq_mask);
      RK_TYPE: rd_val = APB_DW'(irq_type);
      RK_POL:  rd_val = APB_DW'(irq_pol);
      RK_STAT: rd_val = APB_DW'(irq_stat);
      RK_RAW:  rd_val = APB_DW'(irq_raw);
      RK_DEB:  rd_val = APB_DW'(deb_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata_q <= '0;
    else if (setup_rd) prdata_q <= rd_val;
  end

  assign apb_prdata  = prdata_q;
  assign apb_pready  = 1'b1;
  assign apb_pslverr = 1'b0;
endmodule

// File: rtl/gpio_apb_chk.sv
module gpio_apb_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [31:0]          prdata,
  input logic [W-1:0]         vec,
  input logic                 any,
  input logic [W-1:0]         en,
  input logic [W-1:0]         mask,
  input logic [W-1:0]         latch
);
  assert_any_or_R10: assert property (@(posedge clk) disable iff (rst)
    any == (|vec));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (vec & $past(mask)) == '0);

  assert_enable_gates_R9: assert property (@(posedge clk) disable iff (rst)
    (vec & ~$past(en)) == '0);

  assert_latch_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    (latch & ~$past(en)) == '0);

  assert_prdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(psel & ~penable & ~pwrite) |-> $stable(prdata));
endmodule

bind gpio_apb_ctrl gpio_apb_chk #(.W(PORT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .psel    (apb_psel),
  .penable (apb_penable),
  .pwrite  (apb_pwrite),
  .prdata  (apb_prdata),
  .vec     (irq_vec),
  .any     (irq_out),
  .en      (irq_en),
  .mask    (irq_mask),
  .latch   (irq_latch)
);

// File: tb/test_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module test_gpio_apb_ctrl;
  localparam int NP = 4;
  localparam int PW = 32;
  localparam int L  = NP * PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel_m = 1'b0, psel_x = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_m, prdata_x;
  logic        pready_m, pslverr_m, pready_x, pslverr_x;
  logic [L-1:0] gpio_in = '0;
  logic [L-1:0] out_m, oe_m, out_x, oe_x;
  logic [PW-1:0] vec_m, vec_x;
  logic          any_m, any_x;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(PW), .DB_DIV(8), .ALT_MAP(1'b0)) i_gpio_apb_ctrl (
    .clk(clk), .rst(rst), .apb_psel(psel_m), .apb_penable(penable), .apb_pwrite(pwrite),
    .apb_paddr(paddr), .apb_pwdata(pwdata), .apb_prdata(prdata_m), .apb_pready(pready_m),
    .apb_pslverr(pslverr_m), .gpio_in(gpio_in), .gpio_out(out_m), .gpio_oe(oe_m),
    .irq_vec(vec_m), .irq_out(any_m));

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(PW), .DB_DIV(8), .ALT_MAP(1'b1)) i_gpio_apb_ctrl_alt (
    .clk(clk), .rst(rst), .apb_psel(psel_x), .apb_penable(penable), .apb_pwrite(pwrite),
    .apb_paddr(paddr), .apb_pwdata(pwdata), .apb_prdata(prdata_x), .apb_pready(pready_x),
    .apb_pslverr(pslverr_x), .gpio_in(gpio_in), .gpio_out(out_x), .gpio_oe(oe_x),
    .irq_vec(vec_x), .irq_out(any_x));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_m = !alt; psel_x = alt; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel_m = 1'b0; psel_x = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel_m = !alt; psel_x = alt; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = alt ? prdata_x : prdata_m;
    @(negedge clk);
    psel_m = 1'b0; psel_x = 1'b0; penable = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R13 out", 32'(|out_m), 0);
    chk("R13 oe", 32'(|oe_m), 0);
    chk("R13 irq_vec", 32'(vec_m), 0);
    chk("R13 irq_out", 32'(any_m), 0);
    chk("R13 prdata", prdata_m, 0);
    rd(0, 8'h30, d); chk("R13 enable", d, 0);
    rd(0, 8'h48, d); chk("R13 debounce", d, 0);
  endtask

  task automatic t_banks();
    logic [31:0] d, v, o;
    for (int b = 0; b < NP; b++) begin
      v = 32'hA55A0F00 ^ (32'h01010101 * b);
      o = 32'h0FF0F00F ^ (32'h10203040 * b);
      wr(0, 8'(12 * b), v);
      chk("R1 gpio_out", out_m[b*PW +: PW], v);
      wr(0, 8'(12 * b + 4), o);
      chk("R1 gpio_oe", oe_m[b*PW +: PW], o);
      rd(0, 8'(12 * b), d);     chk("R1 data readback", d, v);
      rd(0, 8'(12 * b + 4), d); chk("R1 dir readback", d, o);
    end
  endtask

  task automatic t_pins();
    logic [31:0] d;
    @(negedge clk);
    gpio_in = {32'hDEAD0001, 32'h12345678, 32'h80000001, 32'h0000F0F0};
    idle(4);
    for (int b = 0; b < NP; b++) begin
      rd(0, 8'(8'h50 + 4 * b), d);
      chk("R2 pin read", d, gpio_in[b*PW +: PW]);
    end
    @(negedge clk);
    gpio_in = '0;
    idle(40);
  endtask

  task automatic t_apb();
    logic [31:0] d;
    chk("R3 pready", 32'(pready_m), 1);
    chk("R3 pslverr", 32'(pslverr_m), 0);
    rd(0, 8'h08, d); chk("R3 unmapped 0x08", d, 0);
    rd(0, 8'h2c, d); chk("R3 unmapped 0x2c", d, 0);
    rd(0, 8'h44, d); chk("R3 unmapped 0x44", d, 0);
    rd(0, 8'h70, d); chk("R3 unmapped 0x70", d, 0);
    wr(0, 8'h50, 32'hFFFFFFFF);
    rd(0, 8'h50, d); chk("R3 pin reg write ignored", d, 0);
    wr(0, 8'h40, 32'hFFFFFFFF);
    rd(0, 8'h40, d); chk("R3 status write ignored", d, 0);
    rd(0, 8'h4c, d); chk("R4 eoi reads zero", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(0, 8'h38, 32'h3);
    wr(0, 8'h3c, 32'h1);
    wr(0, 8'h30, 32'h3);
    rd(0, 8'h38, d); chk("R4 type readback", d, 32'h3);
    rd(0, 8'h3c, d); chk("R4 polarity readback", d, 32'h1);
    idle(2);
    chk("R5 idle", 32'(vec_m), 0);
    gpio_in[0] = 1'b1; idle(8);
    chk("R5 rising latched", 32'(vec_m), 32'h1);
    chk("R10 any set", 32'(any_m), 1);
    rd(0, 8'h40, d); chk("R4 status read", d, 32'h1);
    gpio_in[0] = 1'b0; idle(8);
    chk("R5 latch holds", 32'(vec_m), 32'h1);
    gpio_in[1] = 1'b1; idle(8);
    chk("R5 falling line ignores rise", 32'(vec_m), 32'h1);
    gpio_in[1] = 1'b0; idle(8);
    chk("R5 falling latched", 32'(vec_m), 32'h3);
    wr(0, 8'h4c, 32'h1); idle(2);
    chk("R7 eoi clears only bit0", 32'(vec_m), 32'h2);
    wr(0, 8'h4c, 32'hFFFFFFFF); idle(2);
    chk("R7 eoi all", 32'(vec_m), 0);
    chk("R10 any clear", 32'(any_m), 0);
  endtask

  task automatic t_level();
    wr(0, 8'h3c, 32'h11);
    wr(0, 8'h30, 32'h33);
    idle(3);
    chk("R6 active-low line with pin low", 32'(vec_m), 32'h20);
    gpio_in[4] = 1'b1; idle(8);
    chk("R6 active-high line", 32'(vec_m), 32'h30);
    wr(0, 8'h4c, 32'hFFFFFFFF); idle(2);
    chk("R6 eoi no effect on level", 32'(vec_m), 32'h30);
    gpio_in[4] = 1'b0; gpio_in[5] = 1'b1; idle(8);
    chk("R6 level follows pin", 32'(vec_m), 0);
    chk("R10 any follows", 32'(any_m), 0);
    wr(0, 8'h30, 32'h3);
    gpio_in[5] = 1'b0;
    idle(8);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(0, 8'h34, 32'h1);
    gpio_in[0] = 1'b1; idle(8);
    chk("R8 masked vec", 32'(vec_m), 0);
    chk("R8 masked any", 32'(any_m), 0);
    rd(0, 8'h60, d); chk("R8 raw shows", d, 32'h1);
    rd(0, 8'h40, d); chk("R8 status hidden", d, 0);
    wr(0, 8'h34, 32'h0); idle(2);
    chk("R8 unmask reveals", 32'(vec_m), 32'h1);
    wr(0, 8'h4c, 32'hFFFFFFFF);
    gpio_in[0] = 1'b0; idle(8);
    chk("R7 cleared", 32'(vec_m), 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(0, 8'h38, 32'h7);
    wr(0, 8'h3c, 32'h5);
    wr(0, 8'h30, 32'h7);
    gpio_in[2] = 1'b1; idle(8);
    chk("R9 edge on line2", 32'(vec_m), 32'h4);
    wr(0, 8'h30, 32'h3); idle(2);
    chk("R9 disable removes", 32'(vec_m), 0);
    wr(0, 8'h30, 32'h7); idle(2);
    chk("R9 latch cleared by disable", 32'(vec_m), 0);
    wr(0, 8'h30, 32'h3);
    gpio_in[2] = 1'b0; idle(6);
    gpio_in[2] = 1'b1; idle(8);
    wr(0, 8'h30, 32'h7); idle(2);
    chk("R9 disabled edge not latched", 32'(vec_m), 0);
    rd(0, 8'h60, d); chk("R9 raw empty", d, 0);
    gpio_in[2] = 1'b0; idle(8);
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    wr(0, 8'h38, 32'hF);
    wr(0, 8'h3c, 32'hD);
    wr(0, 8'h30, 32'hF);
    wr(0, 8'h48, 32'h8);
    rd(0, 8'h48, d); chk("R4 debounce readback", d, 32'h8);
    gpio_in[3] = 1'b1; idle(2); gpio_in[3] = 1'b0; idle(40);
    chk("R11 glitch rejected", 32'(vec_m), 0);
    gpio_in[3] = 1'b1; idle(40);
    chk("R11 steady level accepted", 32'(vec_m), 32'h8);
    wr(0, 8'h4c, 32'hFFFFFFFF);
    gpio_in[3] = 1'b0; idle(40);
    wr(0, 8'h48, 32'h0);
    idle(2);
    chk("R11 quiet before raw glitch", 32'(vec_m), 0);
    gpio_in[3] = 1'b1; idle(2); gpio_in[3] = 1'b0; idle(8);
    chk("R11 glitch seen without debounce", 32'(vec_m), 32'h8);
    wr(0, 8'h4c, 32'hFFFFFFFF); idle(2);
  endtask

  task automatic t_alt();
    logic [31:0] d;
    wr(1, 8'h44, 32'h0000FF00);
    rd(1, 8'h44, d); chk("R12 mask at 0x44", d, 32'h0000FF00);
    rd(1, 8'h34, d); chk("R12 type at 0x34 untouched", d, 0);
    wr(1, 8'h34, 32'h1);
    rd(1, 8'h34, d); chk("R12 type readback", d, 32'h1);
    rd(1, 8'h44, d); chk("R12 mask kept", d, 32'h0000FF00);
    wr(1, 8'h38, 32'h1);
    rd(1, 8'h38, d); chk("R12 polarity at 0x38", d, 32'h1);
    wr(1, 8'h30, 32'h1);
    gpio_in[0] = 1'b1; idle(8);
    chk("R12 alt edge", 32'(vec_x), 32'h1);
    rd(1, 8'h3c, d); chk("R12 status at 0x3c", d, 32'h1);
    wr(1, 8'h40, 32'h1); idle(2);
    chk("R12 eoi at 0x40", 32'(vec_x), 0);
    gpio_in[0] = 1'b0;
    wr(0, 8'h4c, 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_banks();
    t_pins();
    t_apb();
    t_edge();
    t_level();
    t_mask();
    t_enable();
    t_debounce();
    t_alt();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end
endmodule